// File: doc/BRIEF.md
# Dual-Processor Mailbox Handoff Controller

This controller passes control of a shared system between a requesting processor and a servicing processor, so that the requester can have the servicer carry out low-level I/O work. Only one processor runs at any time. The controller drives a run-enable output for each processor and holds two mailbox registers: a command word and a status word. The requester writes the command word. The servicer writes the status word.

A full exchange runs in four steps. First, the requester loads a command and raises a handoff strobe. The controller then stops the requester and, after a fixed gap in which neither processor runs, starts the servicer. The servicer reads the command, does the work, writes a status word and raises a done strobe. The controller then stops the servicer and, after the same gap, restarts the requester. The requester reads the status word to decide what to do next.

Top module: `mbox_handoff`

## Requirements
- R1: After reset, `req_run_o` is 1, `svc_run_o` is 0, and both the command word and the status word read as zero.
- R2: The command word has address 0. A requester write to address 0 in a cycle where `req_run_o` is 1 stores the data. Both read ports return the stored data at address 0 from the next cycle on.
- R3: A handoff accepted at a clock edge clears `req_run_o` at that edge. Both enables then stay 0 for DEAD_CYC cycles (default 2), and `svc_run_o` rises at the following edge.
- R4: A handoff strobe is accepted only when the requester is running and has written a command in an earlier cycle since the last accepted handoff. Without that command write, the strobe leaves `req_run_o` at 1 and `svc_run_o` at 0.
- R5: The status word has address 1. A servicer write to address 1 in a cycle where `svc_run_o` is 1 stores the data. A done strobe in that state clears `svc_run_o`. After DEAD_CYC dead cycles, `req_run_o` returns to 1 and the requester reads the stored status at address 1.
- R6: `req_run_o` and `svc_run_o` are never 1 in the same cycle, and one enable never rises in the cycle right after the other was 1.
- R7: A write is ignored when the writing side's run-enable is 0. A requester write to address 1 and a servicer write to address 0 are always ignored.
- R8: A handoff strobe is ignored during either switch phase and while the servicer runs. A done strobe is ignored unless `svc_run_o` is 1.
- R9: A write to the command word in the same cycle as an accepted handoff does not count as a new command. Each exchange needs a command written after the previous handoff was accepted. The status word keeps its last written value across later exchanges until the servicer writes it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_we_i | input | 1 | Requester mailbox write enable |
| req_addr_i | input | 1 | Requester mailbox address (0 command, 1 status) |
| req_wdata_i | input | DATA_W | Requester write data |
| req_rdata_o | output | DATA_W | Requester read data at req_addr_i |
| req_handoff_i | input | 1 | Requester asks for a handoff |
| svc_we_i | input | 1 | Servicer mailbox write enable |
| svc_addr_i | input | 1 | Servicer mailbox address (0 command, 1 status) |
| svc_wdata_i | input | DATA_W | Servicer write data |
| svc_rdata_o | output | DATA_W | Servicer read data at svc_addr_i |
| svc_done_i | input | 1 | Servicer signals the task is complete |
| req_run_o | output | 1 | Run enable of the requesting processor |
| svc_run_o | output | 1 | Run enable of the servicing processor |

## Verification
The hardest situations to reach are the dead cycles. In those cycles both enables are low, and stray handoff strobes and writes from either side must leave no trace. The bench reaches them by driving a complete exchange for each command value in a sweep. In every dead cycle it injects handoff strobes, done strobes and writes from both sides, then checks afterwards through the read ports and enables that nothing changed. Each round also fires a second handoff with no new command and a done strobe while the requester runs, to exercise the pending-command rule.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    REQ_RUN       = 2'd0,
    SWITCH_TO_SVC = 2'd1,
    SVC_RUN       = 2'd2,
    SWITCH_TO_REQ = 2'd3
  } hs_state_e;

  localparam logic ADDR_CMD  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/mbox_gap_cnt.sv
module mbox_gap_cnt #(
  parameter int DEAD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic last_o
);
  localparam int CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEAD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!active_i || last_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = active_i && (cnt_q == LAST);

  AST_GAP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R3
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic handoff_i,
  input  logic pend_i,
  input  logic done_i,
  output logic accept_o,
  output logic req_run_o,
  output logic svc_run_o
);
  hs_state_e state_q, state_d;
  logic      in_switch;
  logic      gap_last;

  assign in_switch = (state_q == SWITCH_TO_SVC) || (state_q == SWITCH_TO_REQ);
  assign accept_o  = (state_q == REQ_RUN) && handoff_i && pend_i;

  mbox_gap_cnt #(.DEAD_CYC(DEAD_CYC)) gap_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(in_switch),
    .last_o  (gap_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      REQ_RUN:       if (accept_o) state_d = SWITCH_TO_SVC;
      SWITCH_TO_SVC: if (gap_last) state_d = SVC_RUN;
      SVC_RUN:       if (done_i)   state_d = SWITCH_TO_REQ;
      SWITCH_TO_REQ: if (gap_last) state_d = REQ_RUN;
      default:                     state_d = REQ_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= REQ_RUN;
    else         state_q <= state_d;
  end

  assign req_run_o = (state_q == REQ_RUN);
  assign svc_run_o = (state_q == SVC_RUN);

  AST_ONE_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_run_o && svc_run_o)); // R6
  AST_SVC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(svc_run_o) |-> !$past(req_run_o)); // R6
  AST_REQ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_run_o) |-> !$past(svc_run_o)); // R6
  AST_HANDOFF_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_run_o) |-> $past(handoff_i && pend_i)); // R4
  AST_DONE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(svc_run_o) |-> $past(done_i)); // R8
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_en_i,
  input  logic              svc_en_i,
  input  logic              accept_i,
  input  logic              req_we_i,
  input  logic              req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              svc_we_i,
  input  logic              svc_addr_i,
  input  logic [DATA_W-1:0] svc_wdata_i,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic [DATA_W-1:0] svc_rdata_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] cmd_q, stat_q;
  logic              pend_q;
  logic              cmd_wr, stat_wr;

  assign cmd_wr  = req_en_i && req_we_i && (req_addr_i == ADDR_CMD);
  assign stat_wr = svc_en_i && svc_we_i && (svc_addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      stat_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cmd_wr)  cmd_q  <= req_wdata_i;
      if (stat_wr) stat_q <= svc_wdata_i;
      if (accept_i)    pend_q <= 1'b0;
      else if (cmd_wr) pend_q <= 1'b1;
    end
  end

  assign req_rdata_o = (req_addr_i == ADDR_STAT) ? stat_q : cmd_q;
  assign svc_rdata_o = (svc_addr_i == ADDR_STAT) ? stat_q : cmd_q;
  assign pend_o      = pend_q;

  AST_CMD_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_en_i |=> $stable(cmd_q)); // R7
  AST_STAT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svc_en_i |=> $stable(stat_q)); // R7
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !pend_q); // R9
endmodule

// File: rtl/mbox_handoff.sv
module mbox_handoff
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEAD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_we_i,
  input  logic              req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] req_rdata_o,
  input  logic              req_handoff_i,
  input  logic              svc_we_i,
  input  logic              svc_addr_i,
  input  logic [DATA_W-1:0] svc_wdata_i,
  output logic [DATA_W-1:0] svc_rdata_o,
  input  logic              svc_done_i,
  output logic              req_run_o,
  output logic              svc_run_o
);
  logic accept, pend;

  mbox_seq #(.DEAD_CYC(DEAD_CYC)) seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .handoff_i(req_handoff_i),
    .pend_i   (pend),
    .done_i   (svc_done_i),
    .accept_o (accept),
    .req_run_o(req_run_o),
    .svc_run_o(svc_run_o)
  );

  mbox_regs #(.DATA_W(DATA_W)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_en_i   (req_run_o),
    .svc_en_i   (svc_run_o),
    .accept_i   (accept),
    .req_we_i   (req_we_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .svc_we_i   (svc_we_i),
    .svc_addr_i (svc_addr_i),
    .svc_wdata_i(svc_wdata_i),
    .req_rdata_o(req_rdata_o),
    .svc_rdata_o(svc_rdata_o),
    .pend_o     (pend)
  );

  AST_RST_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> req_run_o); // R1
endmodule

// File: tb/mbox_handoff_tb.sv
`timescale 1ns/1ps
module mbox_handoff_tb_top;
  localparam int DW   = 8;
  localparam int DEAD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_we = 0, req_addr = 0, req_ho = 0;
  logic svc_we = 0, svc_addr = 0, svc_done = 0;
  logic [DW-1:0] req_wd = '0, svc_wd = '0;
  logic [DW-1:0] req_rd, svc_rd;
  logic req_run, svc_run;
  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] last_stat;

  always #2 clk = ~clk;

  mbox_handoff #(.DATA_W(DW), .DEAD_CYC(DEAD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wd),
    .req_rdata_o(req_rd), .req_handoff_i(req_ho),
    .svc_we_i(svc_we), .svc_addr_i(svc_addr), .svc_wdata_i(svc_wd),
    .svc_rdata_o(svc_rd), .svc_done_i(svc_done),
    .req_run_o(req_run), .svc_run_o(svc_run)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    req_we = 0; req_ho = 0; svc_we = 0; svc_done = 0;
  endtask

  task automatic runs(input string req, input int r, input int s);
    chk(req, req_run, r);
    chk(req, svc_run, s);
    chk({req, "_R6"}, int'(req_run & svc_run), 0);
  endtask

  // stray traffic during a dead cycle; nothing may change
  task automatic stray(input logic [DW-1:0] v);
    req_ho = 1; svc_done = 1;
    req_we = 1; req_addr = 0; req_wd = ~v;
    svc_we = 1; svc_addr = 1; svc_wd = ~v;
  endtask

  task automatic round(input logic [DW-1:0] v);
    logic [DW-1:0] s;
    s = v ^ 8'h5A;
    // R2: command load
    req_we = 1; req_addr = 0; req_wd = v; step(); idle();
    req_addr = 0; svc_addr = 0; #0.1;
    chk("R2", req_rd, v); chk("R2", svc_rd, v);
    // R7: requester write to status ignored
    req_we = 1; req_addr = 1; req_wd = ~last_stat; step(); idle();
    req_addr = 1; #0.1; chk("R7", req_rd, last_stat);
    // R3: handoff
    req_ho = 1; step(); idle();
    runs("R3", 0, 0);
    for (int k = 1; k < DEAD; k++) begin
      stray(v); step(); idle();
      runs("R8", 0, 0);
    end
    stray(v); step(); idle();
    runs("R3", 0, 1);
    svc_addr = 0; svc_wd = '0; #0.1; chk("R7", svc_rd, v);
    svc_addr = 1; #0.1; chk("R7", svc_rd, last_stat);
    // R7/R8 in SVC_RUN: req write, svc cmd write, handoff ignored
    req_we = 1; req_addr = 0; req_wd = ~v; req_ho = 1;
    svc_we = 1; svc_addr = 0; svc_wd = ~v; step(); idle();
    runs("R8", 0, 1);
    svc_addr = 0; #0.1; chk("R7", svc_rd, v);
    // R5: status write + done
    svc_we = 1; svc_addr = 1; svc_wd = s; step(); idle();
    svc_addr = 1; #0.1; chk("R5", svc_rd, s);
    svc_done = 1; step(); idle();
    runs("R5", 0, 0);
    for (int k = 1; k < DEAD; k++) begin
      stray(v); step(); idle();
      runs("R8", 0, 0);
    end
    stray(v); step(); idle();
    runs("R5", 1, 0);
    last_stat = s;
    req_addr = 1; #0.1; chk("R5", req_rd, s);
    req_addr = 0; #0.1; chk("R7", req_rd, v);
    // R9: no new command -> handoff ignored; done ignored in REQ_RUN
    req_ho = 1; svc_done = 1; step(); idle();
    runs("R9", 1, 0);
    step(); runs("R8", 1, 0);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    last_stat = '0;
    #9 rst_n = 1; step();
    runs("R1", 1, 0);
    req_addr = 0; svc_addr = 1; #0.1;
    chk("R1", req_rd, 0); chk("R1", svc_rd, 0);
    // R4: handoff without a command
    req_ho = 1; step(); idle(); runs("R4", 1, 0);
    // R9: command written in the same cycle as handoff -> not pending
    req_we = 1; req_addr = 0; req_wd = 8'h11; step(); idle();
    req_we = 1; req_wd = 8'h22; req_ho = 1; step(); idle();
    runs("R3", 0, 0);
    for (int k = 0; k < DEAD; k++) step();
    runs("R3", 0, 1);
    svc_done = 1; step(); idle();
    for (int k = 0; k < DEAD; k++) step();
    runs("R5", 1, 0);
    req_ho = 1; step(); idle(); runs("R9", 1, 0);
    for (int v = 0; v < 256; v += 7) round(DW'(v));
    round(8'hFF);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule